// File: doc/BRIEF.md
# Dirty Replica Backup Cache

This block holds a second copy of dirty data for cache blocks whose error-correcting code is fully spent on masking manufacturing defects. A block like that has no spare correction strength left for a soft error. A clean block can be fetched again from memory, but a dirty block cannot. So whenever a defective block is made dirty, its new contents are also written into this small fully associative store. When the L2 later reports an uncorrectable error on a block, the requester looks the address up here. A hit returns the good copy. A miss means the block was clean and must be refetched from memory.

Writes that are not flagged defective are ignored. A repeated dirty write to an address that is already held updates that entry in place. When the store is full, the least recently written entry is pushed out through a ready/valid write-back channel to main memory, so every dirty defective block always has either a replica here or an up-to-date copy in memory. When the L2 writes a block back itself, or invalidates it, it sends a drop notice. The matching replica is then discarded with no memory traffic.

Top module: `drc_cache`

## Requirements
- R1: After reset the store is empty: every lookup misses, `wb_valid` is low and `wr_ready` is high.
- R2: A dirty write with `wr_defect`=1 to a new address is stored when `wr_valid` and `wr_ready` are both high at a clock edge. A lookup of that address returns `rsp_valid`=1, `rsp_hit`=1 and the written data in the cycle after `lk_valid`.
- R3: A write with `wr_defect`=0 is accepted (`wr_ready`=1) but stores nothing and never raises `wb_valid`.
- R4: A defective write to an address already held overwrites that entry's data in place. It takes no new entry and causes no write-back, even when the store is full.
- R5: A lookup of an address that is not held returns `rsp_valid`=1 and `rsp_hit`=0 one cycle later.
- R6: A defective write to a new address while all ENTRIES entries are valid raises `wb_valid` with the address and data of the victim. On acceptance the victim is removed and the new block takes its slot.
- R7: The victim is the entry whose last write (allocation or in-place update) is the oldest. Lookups do not change this order.
- R8: While an eviction is pending and `wb_ready`=0, `wr_ready` stays 0, `wb_valid` stays 1 and the store is unchanged.
- R9: A drop notice for a held address invalidates that entry with no write-back. The freed slot is reused by the next allocation. A drop notice for an address that is not held changes nothing.
- R10: In any cycle with `drop_valid`=1, `wr_ready`=0 and `wb_valid`=0, so a write is never accepted in the same cycle as a drop.
- R11: Up to ENTRIES distinct addresses are held at once with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Block-made-dirty event |
| wr_ready | output | 1 | Write event accepted this cycle |
| wr_addr | input | ADDR_W | Block address of dirty write |
| wr_data | input | DATA_W | New block data |
| wr_defect | input | 1 | Block contains defective cells |
| lk_valid | input | 1 | Lookup after an uncorrectable error |
| lk_addr | input | ADDR_W | Lookup address |
| rsp_valid | output | 1 | Lookup response, one cycle after request |
| rsp_hit | output | 1 | Replica found |
| rsp_data | output | DATA_W | Replica data (valid when hit) |
| drop_valid | input | 1 | L2 wrote back or invalidated a block |
| drop_addr | input | ADDR_W | Address of dropped block |
| wb_valid | output | 1 | Victim write-back request |
| wb_ready | input | 1 | Memory accepts write-back |
| wb_addr | output | ADDR_W | Victim address |
| wb_data | output | DATA_W | Victim data |

## Verification
The bench fills the store to capacity and then rewrites a held address. A design that allocated instead of updating would push out a block too early and raise a write-back. It refreshes one entry by writing it and leaves another untouched apart from a lookup. The victim must then be the lookup-only entry; a design that aged entries on lookups, or picked the first allocated entry, sends the wrong address. It drops an entry, refills the hole and holds `wb_ready` low during an eviction. A design that leaked a write-back on drop, overwrote the victim before the handshake, or accepted a write during a drop would show the wrong port values or a missing or extra hit.

// File: rtl/drc_pkg.sv
package drc_pkg;

   // What a presented dirty write will do to the store
   typedef enum logic [1:0] {
      WACT_NONE   = 2'd0,  // nothing stored (clean, stalled or absent)
      WACT_UPDATE = 2'd1,  // address present, rewrite in place
      WACT_ALLOC  = 2'd2,  // free slot available
      WACT_EVICT  = 2'd3   // store full, LRU victim goes to memory
   } wr_action_e;

endpackage

// File: rtl/drc_cam.sv
module drc_cam #(
   parameter int ENTRIES = 64,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [ADDR_W-1:0]  tags [ENTRIES],
   input  logic [ADDR_W-1:0]  key,
   output logic [ENTRIES-1:0] match,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == key);
   end

   assign hit = |match;

   // tags are unique, so at most one match bit is set and OR-encoding is exact
   always_comb begin
      idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/drc_lru.sv
module drc_lru #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid,
   input  logic               touch_en,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic               drop_en,
   input  logic [IDX_W-1:0]   drop_idx,
   output logic [IDX_W-1:0]   victim_idx
);

   // Age 0 is most recent; valid entries always hold ages 0..count-1
   logic [IDX_W-1:0] age_q [ENTRIES];
   logic [IDX_W:0]   touch_ref;
   logic [IDX_W-1:0] drop_age;

   assign touch_ref = valid[touch_idx] ? {1'b0, age_q[touch_idx]} : (IDX_W+1)'(ENTRIES);
   assign drop_age  = age_q[drop_idx];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q[g] <= '0;
         end else if (touch_en) begin
            if (touch_idx == IDX_W'(g))
               age_q[g] <= '0;
            else if (valid[g] && ({1'b0, age_q[g]} < touch_ref))
               age_q[g] <= age_q[g] + 1'b1;
         end else if (drop_en) begin
            if (valid[g] && (age_q[g] > drop_age))
               age_q[g] <= age_q[g] - 1'b1;
         end
      end
   end

   // Only consulted when full, where exactly one entry has the top age
   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/drc_cache.sv
module drc_cache #(
   parameter int ENTRIES = 64,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_defect,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   input  logic              drop_valid,
   input  logic [ADDR_W-1:0] drop_addr,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0] wb_data
);
   import drc_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("drc_cache: ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("drc_cache: ADDR_W and DATA_W must be positive");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [ADDR_W-1:0]  tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];

   logic [ENTRIES-1:0] wr_match, lk_match, dr_match;
   logic               wr_hit, lk_hit, dr_hit;
   logic [IDX_W-1:0]   wr_idx, lk_idx, dr_idx;
   logic [IDX_W-1:0]   victim_idx, free_idx, tgt_idx;
   logic               full;
   wr_action_e         wact;
   logic               wr_fire, drop_fire;

   drc_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam_wr (
      .valid(valid_q), .tags(tag_q), .key(wr_addr),
      .match(wr_match), .hit(wr_hit), .idx(wr_idx));

   drc_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam_lk (
      .valid(valid_q), .tags(tag_q), .key(lk_addr),
      .match(lk_match), .hit(lk_hit), .idx(lk_idx));

   drc_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam_dr (
      .valid(valid_q), .tags(tag_q), .key(drop_addr),
      .match(dr_match), .hit(dr_hit), .idx(dr_idx));

   assign full = &valid_q;

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (!wr_valid || !wr_defect || drop_valid) wact = WACT_NONE;
      else if (wr_hit)                           wact = WACT_UPDATE;
      else if (!full)                            wact = WACT_ALLOC;
      else                                       wact = WACT_EVICT;
   end

   always_comb begin
      unique case (wact)
         WACT_UPDATE: tgt_idx = wr_idx;
         WACT_EVICT:  tgt_idx = victim_idx;
         default:     tgt_idx = free_idx;
      endcase
   end

   assign wb_valid  = (wact == WACT_EVICT);
   assign wb_addr   = tag_q[victim_idx];
   assign wb_data   = data_q[victim_idx];
   assign wr_ready  = !drop_valid && !(wb_valid && !wb_ready);
   assign wr_fire   = (wact != WACT_NONE) && wr_ready;
   assign drop_fire = drop_valid && dr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_fire) begin
         valid_q[tgt_idx] <= 1'b1;
      end else if (drop_fire) begin
         valid_q[dr_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         tag_q[tgt_idx]  <= wr_addr;
         data_q[tgt_idx] <= wr_data;
      end
   end

   drc_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .valid(valid_q),
      .touch_en(wr_fire), .touch_idx(tgt_idx),
      .drop_en(drop_fire), .drop_idx(dr_idx),
      .victim_idx(victim_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && lk_hit;
         rsp_data  <= (lk_valid && lk_hit) ? data_q[lk_idx] : '0;
      end
   end

endmodule

// File: rtl/drc_cache_chk.sv
module drc_cache_chk #(
   parameter int ENTRIES = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_valid,
   input logic               wr_defect,
   input logic               wr_ready,
   input logic               lk_valid,
   input logic               rsp_valid,
   input logic               drop_valid,
   input logic               wb_valid,
   input logic               wb_ready,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] wr_match
);

   assert_rsp_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   assert_clean_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wr_valid && wr_defect));

   assert_clean_accepted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_defect && !drop_valid) |-> wr_ready);

   assert_unique_tags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_match));

   assert_evict_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (&valid_q));

   assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> $stable(valid_q));

   assert_drop_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drop_valid |-> (!wr_ready && !wb_valid));

endmodule

bind drc_cache drc_cache_chk #(.ENTRIES(ENTRIES)) u_drc_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_defect(wr_defect),
   .wr_ready(wr_ready), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
   .drop_valid(drop_valid), .wb_valid(wb_valid), .wb_ready(wb_ready),
   .valid_q(valid_q), .wr_match(wr_match));

// File: tb/drc_cache_bench.sv
module drc_cache_bench;

   localparam int N  = 8;
   localparam int AW = 32;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_defect = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          rsp_valid, rsp_hit;
   logic [DW-1:0] rsp_data;
   logic          drop_valid = 1'b0;
   logic [AW-1:0] drop_addr = '0;
   logic          wb_valid;
   logic          wb_ready = 1'b1;
   logic [AW-1:0] wb_addr;
   logic [DW-1:0] wb_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   drc_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_drc_cache (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_defect(wr_defect),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .drop_valid(drop_valid), .drop_addr(drop_addr),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data));

   function automatic logic [AW-1:0] A(int i);
      return AW'(32'h0004_0000 + i * 64);
   endfunction

   function automatic logic [DW-1:0] D(int i);
      return {32'hC0DE_0000 + 32'(i), ~(32'h5A00_0000 + 32'(i))};
   endfunction

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Present a write for one cycle with wb_ready high; check the handshake outputs
   task automatic do_write(int ai, int di, bit def, bit exp_wb, int exp_vi, string req);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = A(ai); wr_data = D(di); wr_defect = def;
      #1;
      chk(wr_ready == 1'b1, req, DW'(wr_ready), 1);
      chk(wb_valid == exp_wb, req, DW'(wb_valid), DW'(exp_wb));
      if (exp_wb) begin
         chk(wb_addr == A(exp_vi), req, DW'(wb_addr), DW'(A(exp_vi)));
         chk(wb_data == D(exp_vi), req, wb_data, D(exp_vi));
      end
      @(negedge clk);
      wr_valid = 1'b0; wr_defect = 1'b0;
   endtask

   task automatic do_lookup(int ai, bit exp_hit, int di, string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = A(ai);
      @(negedge clk);
      lk_valid = 1'b0;
      chk(rsp_valid == 1'b1, req, DW'(rsp_valid), 1);
      chk(rsp_hit == exp_hit, req, DW'(rsp_hit), DW'(exp_hit));
      if (exp_hit) chk(rsp_data == D(di), req, rsp_data, D(di));
   endtask

   task automatic do_drop(int ai);
      @(negedge clk);
      drop_valid = 1'b1; drop_addr = A(ai);
      #1;
      chk(wb_valid == 1'b0, "R9", DW'(wb_valid), 0);
      @(negedge clk);
      drop_valid = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk(wr_ready == 1'b1, "R1", DW'(wr_ready), 1);
      chk(wb_valid == 1'b0, "R1", DW'(wb_valid), 0);
      chk(rsp_valid == 1'b0, "R1", DW'(rsp_valid), 0);
      do_lookup(0, 1'b0, 0, "R1");
   endtask

   task automatic t_clean_ignored;
      do_write(0, 0, 1'b0, 1'b0, 0, "R3");
      do_lookup(0, 1'b0, 0, "R3");
   endtask

   task automatic t_fill;
      for (int i = 0; i < N; i++) do_write(i, i, 1'b1, 1'b0, 0, "R11");
      do_lookup(3, 1'b1, 3, "R2");
      do_lookup(7, 1'b1, 7, "R11");
      do_lookup(20, 1'b0, 0, "R5");
   endtask

   task automatic t_rewrite;
      // store is full: allocating instead of updating would raise wb_valid
      do_write(0, 100, 1'b1, 1'b0, 0, "R4");
      do_lookup(0, 1'b1, 100, "R4");
   endtask

   task automatic t_lru;
      do_lookup(1, 1'b1, 1, "R7");              // lookup must not refresh A1
      do_write(8, 8, 1'b1, 1'b1, 1, "R7");      // oldest write is A1 (A0 was rewritten)
      do_lookup(1, 1'b0, 0, "R6");
      do_lookup(8, 1'b1, 8, "R6");
      do_write(9, 9, 1'b1, 1'b1, 2, "R6");
   endtask

   task automatic t_drop;
      do_drop(3);
      do_lookup(3, 1'b0, 0, "R9");
      do_drop(50);                               // absent address
      do_lookup(4, 1'b1, 4, "R9");
      do_write(10, 10, 1'b1, 1'b0, 0, "R9");    // refills the freed slot
      do_write(11, 11, 1'b1, 1'b1, 4, "R7");    // order now A4 oldest
   endtask

   task automatic t_stall;
      @(negedge clk);
      wb_ready = 1'b0;
      wr_valid = 1'b1; wr_addr = A(12); wr_data = D(12); wr_defect = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk(wr_ready == 1'b0, "R8", DW'(wr_ready), 0);
         chk(wb_valid == 1'b1, "R8", DW'(wb_valid), 1);
         chk(wb_addr == A(5), "R8", DW'(wb_addr), DW'(A(5)));
         @(negedge clk);
      end
      do_lookup(5, 1'b1, 5, "R8");
      do_lookup(12, 1'b0, 0, "R8");
      wb_ready = 1'b1;
      #1;
      chk(wr_ready == 1'b1, "R8", DW'(wr_ready), 1);
      @(negedge clk);
      wr_valid = 1'b0; wr_defect = 1'b0;
      do_lookup(12, 1'b1, 12, "R6");
      do_lookup(5, 1'b0, 0, "R6");
   endtask

   task automatic t_drop_collide;
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = A(13); wr_data = D(13); wr_defect = 1'b1;
      drop_valid = 1'b1; drop_addr = A(6);
      #1;
      chk(wr_ready == 1'b0, "R10", DW'(wr_ready), 0);
      chk(wb_valid == 1'b0, "R10", DW'(wb_valid), 0);
      @(negedge clk);
      drop_valid = 1'b0;
      #1;
      chk(wr_ready == 1'b1, "R10", DW'(wr_ready), 1);
      chk(wb_valid == 1'b0, "R9", DW'(wb_valid), 0);
      @(negedge clk);
      wr_valid = 1'b0; wr_defect = 1'b0;
      do_lookup(6, 1'b0, 0, "R9");
      do_lookup(13, 1'b1, 13, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clean_ignored();
      t_fill();
      t_rewrite();
      t_lru();
      t_drop();
      t_stall();
      t_drop_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule